// File: doc/BRIEF.md
# Color Bar Frame Writer

This block produces an endless stream of full frames for a small serial colour panel once the panel has been brought up. Each frame is one command byte (the memory-write opcode) followed by the pixel payload in 16-bit 5-6-5 colour, two bytes per pixel, in raster order. The picture is three vertical bands of solid colour. The block swaps between two band orders on a fixed wall-clock period.

The byte stream leaves through a valid/ready port. `out_valid` stays high from the first frame onward, because there is always another byte to send. The downstream serializer accepts a byte by holding `out_ready` high on a clock edge where `out_valid` is high. While `out_ready` is low, the byte and its flags are held unchanged, with no limit on the stall length. `out_dc` tells a command byte (0) from a data byte (1), which is the level the serializer drives on the panel's data/command line. `out_last` marks the final byte of a frame, so the serializer can release chip select after it and only there. The panel size, the swap period and a simulation override of that period are parameters.

Top module: `bar_frame_writer`

## Requirements
- R1: After reset `out_valid` is low. It stays low until `init_done` is sampled high on a clock edge, and it goes high on the following cycle.
- R2: Every frame starts with byte 0x2C carrying `out_dc`=0. It is followed by exactly 2·H_PIX·V_PIX bytes carrying `out_dc`=1.
- R3: `out_last` is high on the final data byte of a frame and low on every other byte.
- R4: Pixels run row by row from the top row, left to right within a row. Each pixel is sent as its high byte first, then its low byte.
- R5: The width is split into three equal bands of H_PIX/3 columns. A column's band is its column index divided by that width.
- R6: The colour codes are red 0xF800, green 0x07E0 and blue 0x001F. Pattern A (select 0) shows red, green, blue from left to right. Pattern B (select 1) shows blue, red, green.
- R7: The pattern select starts at 0 on reset. It flips every P cycles, where P is PERIOD_OVERRIDE when that is non-zero and CLK_HZ·SWAP_SEC otherwise. The frame that starts with a command byte accepted after n post-reset edges uses select (n/P) mod 2.
- R8: All data bytes of one frame use the same pattern. A swap takes effect only at the next command byte.
- R9: While `out_valid` is high and `out_ready` is low, `out_byte`, `out_dc` and `out_last` hold their values into the next cycle.
- R10: The next command byte is offered in the cycle right after the `out_last` byte is accepted. Once streaming has begun, `out_valid` stays high, even if `init_done` later falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_done | input | 1 | Panel bring-up finished; starts streaming |
| out_valid | output | 1 | A byte is offered |
| out_ready | input | 1 | Serializer accepts the offered byte |
| out_byte | output | 8 | Byte value |
| out_dc | output | 1 | 0 = command byte, 1 = pixel data byte |
| out_last | output | 1 | Final byte of the current frame |

## Verification
If the raster position goes wrong, a wrong byte value or a misplaced `out_last` shows up within one band width of columns. A missing or extra byte moves the next 0x2C and is flagged on the first byte after it. A swap timer that runs fast or slow, or that fires mid-frame, changes the colour order of the first frame latched after the expected swap edge. That is visible on its very first data byte. A stall that lets the counters slip appears as a changed byte in the cycle after `out_ready` is low.

// File: rtl/bar_pkg.sv
package bar_pkg;
  localparam logic [7:0]  OPC_MEM_WRITE = 8'h2C;
  localparam logic [15:0] COL_RED   = 16'hF800;
  localparam logic [15:0] COL_GREEN = 16'h07E0;
  localparam logic [15:0] COL_BLUE  = 16'h001F;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_PIX  = 2'd2
  } wr_state_e;

  // Band colour for index 0..2 after rotation.
  function automatic logic [15:0] hue_of(input logic [1:0] idx);
    case (idx)
      2'd0:    hue_of = COL_RED;
      2'd1:    hue_of = COL_GREEN;
      default: hue_of = COL_BLUE;
    endcase
  endfunction
endpackage

// File: rtl/bar_swap_timer.sv
module bar_swap_timer #(
  parameter int unsigned CLK_HZ          = 50_000_000,
  parameter int unsigned SWAP_SEC        = 3,
  parameter int unsigned PERIOD_OVERRIDE = 0
) (
  input  logic clk,
  input  logic rst_n,
  output logic pat_sel
);
  localparam longint unsigned PERIOD =
    (PERIOD_OVERRIDE != 0) ? longint'(PERIOD_OVERRIDE)
                           : longint'(CLK_HZ) * longint'(SWAP_SEC);
  localparam int TW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      pat_sel <= 1'b0;
    end else if (cnt == TW'(PERIOD - 1)) begin
      cnt     <= '0;
      pat_sel <= ~pat_sel;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/bar_raster_walk.sv
module bar_raster_walk #(
  parameter int H_PIX = 240,
  parameter int V_PIX = 320,
  localparam int CW = $clog2(H_PIX),
  localparam int RW = $clog2(V_PIX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [CW-1:0] col,
  output logic          lo_half,
  output logic          at_end
);
  logic [RW-1:0] row;
  logic          col_end;
  logic          row_end;

  assign col_end = (col == CW'(H_PIX - 1));
  assign row_end = (row == RW'(V_PIX - 1));
  assign at_end  = lo_half && col_end && row_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col     <= '0;
      row     <= '0;
      lo_half <= 1'b0;
    end else if (step) begin
      lo_half <= ~lo_half;
      if (lo_half) begin
        if (col_end) begin
          col <= '0;
          row <= row_end ? '0 : row + 1'b1;
        end else begin
          col <= col + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bar_color_pick.sv
module bar_color_pick
  import bar_pkg::*;
#(
  parameter int H_PIX = 240,
  localparam int CW = $clog2(H_PIX),
  localparam int BAND_W = H_PIX / 3
) (
  input  logic [CW-1:0] col,
  input  logic          pat,
  output logic [15:0]   rgb
);
  logic [1:0] band;
  logic [1:0] idx;

  always_comb begin
    if (col < CW'(BAND_W))          band = 2'd0;
    else if (col < CW'(2 * BAND_W)) band = 2'd1;
    else                            band = 2'd2;
    // Pattern B rotates the order by two places.
    if (pat) idx = (band == 2'd0) ? 2'd2 : band - 2'd1;
    else     idx = band;
    rgb = hue_of(idx);
  end
endmodule

// File: rtl/bar_frame_writer.sv
module bar_frame_writer
  import bar_pkg::*;
#(
  parameter int          H_PIX           = 240,
  parameter int          V_PIX           = 320,
  parameter int unsigned CLK_HZ          = 50_000_000,
  parameter int unsigned SWAP_SEC        = 3,
  parameter int unsigned PERIOD_OVERRIDE = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init_done,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_byte,
  output logic       out_dc,
  output logic       out_last
);
  localparam int CW = $clog2(H_PIX);

  wr_state_e     state;
  logic          pat_sel;
  logic          frame_pat;
  logic          fire;
  logic          pix_step;
  logic [CW-1:0] col;
  logic          lo_half;
  logic          at_end;
  logic [15:0]   rgb;

  bar_swap_timer #(
    .CLK_HZ(CLK_HZ), .SWAP_SEC(SWAP_SEC), .PERIOD_OVERRIDE(PERIOD_OVERRIDE)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .pat_sel(pat_sel)
  );

  bar_raster_walk #(.H_PIX(H_PIX), .V_PIX(V_PIX)) u_walk (
    .clk(clk), .rst_n(rst_n), .step(pix_step),
    .col(col), .lo_half(lo_half), .at_end(at_end)
  );

  bar_color_pick #(.H_PIX(H_PIX)) u_pick (
    .col(col), .pat(frame_pat), .rgb(rgb)
  );

  assign fire     = out_valid && out_ready;
  assign pix_step = fire && (state == ST_PIX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      frame_pat <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (init_done) state <= ST_CMD;
        ST_CMD: if (fire) begin
          frame_pat <= pat_sel;
          state     <= ST_PIX;
        end
        ST_PIX: if (fire && at_end) state <= ST_CMD;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    out_valid = (state != ST_IDLE);
    out_dc    = (state == ST_PIX);
    out_last  = (state == ST_PIX) && at_end;
    if (state == ST_PIX) out_byte = lo_half ? rgb[7:0] : rgb[15:8];
    else                 out_byte = OPC_MEM_WRITE;
  end
endmodule

// File: rtl/bar_frame_writer_chk.sv
module bar_frame_writer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       init_done,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_byte,
  input logic       out_dc,
  input logic       out_last
);
  a_r1_wait_for_init: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !init_done) |=> !out_valid);

  a_r2_cmd_opcode: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_dc) |-> (out_byte == 8'h2C));

  a_r3_last_on_data: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> (out_valid && out_dc));

  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_byte) && $stable(out_dc) && $stable(out_last)));

  a_r10_cmd_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (out_valid && !out_dc));

  a_r10_keeps_streaming: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> out_valid);
endmodule

bind bar_frame_writer bar_frame_writer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .init_done(init_done),
  .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
  .out_dc(out_dc), .out_last(out_last)
);

// File: tb/bar_frame_writer_tb.sv
module bar_frame_writer_tb;
  localparam int W = 12;
  localparam int H = 4;
  localparam int P = 300;
  localparam int BW = W / 3;
  localparam int FRAME_DATA = 2 * W * H;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       init_done = 1'b0;
  logic       out_ready = 1'b0;
  logic       out_valid;
  logic [7:0] out_byte;
  logic       out_dc;
  logic       out_last;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bar_frame_writer #(
    .H_PIX(W), .V_PIX(H), .CLK_HZ(50_000_000), .SWAP_SEC(3), .PERIOD_OVERRIDE(P)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .init_done(init_done), .out_valid(out_valid),
    .out_ready(out_ready), .out_byte(out_byte), .out_dc(out_dc), .out_last(out_last)
  );

  function automatic logic [15:0] colour(input int band, input bit pat);
    int k;
    k = pat ? (band + 2) % 3 : band;
    if (k == 0) return 16'hF800;
    if (k == 1) return 16'h07E0;
    return 16'h001F;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  initial begin
    bit started = 1'b0;
    int idx = 0;
    bit fpat = 1'b0;
    int n = 0;
    int frames = 0;
    int pat_b_frames = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int it = 0; it < 6000; it++) begin
      // R1: quiet before start; R10: stays valid after start
      check(out_valid == started, started ? "R10" : "R1", out_valid, started);
      if (started) begin
        if (idx == 0) begin
          check(out_dc == 1'b0 && out_byte == 8'h2C, "R2", {out_dc, out_byte}, 8'h2C);
          check(out_last == 1'b0, "R3", out_last, 0);
        end else begin
          int p;
          int c;
          logic [15:0] rgb;
          logic [7:0] eb;
          p = (idx - 1) / 2;
          c = p % W;
          rgb = colour(c / BW, fpat);           // R5 R6 R8
          eb = ((idx - 1) % 2 == 0) ? rgb[15:8] : rgb[7:0];  // R4
          check(out_dc == 1'b1, "R2", out_dc, 1);
          check(out_byte == eb, fpat ? "R6/R7 patB" : "R4/R5 patA", out_byte, eb);
          check(out_last == (idx == FRAME_DATA), "R3", out_last, idx == FRAME_DATA);
        end
      end
      // stimulus for the coming edge
      if (n == 20) init_done = 1'b1;
      if (n == 700) init_done = 1'b0;  // R10: no effect
      if (n >= 1000 && n < 1012) out_ready = 1'b0;   // R9 long stall
      else if (n < 2500) out_ready = ($urandom_range(0, 3) != 0);
      else out_ready = 1'b1;
      // model update at the edge
      if (started && out_ready) begin
        if (idx == 0) begin
          fpat = ((n / P) % 2) == 1;   // R7
          frames++;
          if (fpat) pat_b_frames++;
        end
        idx = (idx == FRAME_DATA) ? 0 : idx + 1;
      end
      if (!started && init_done) started = 1'b1;
      @(negedge clk);
      n++;
    end
    check(frames > 20, "R7 frame count", frames, 21);
    check(pat_b_frames > 5, "R7 pattern B frames", pat_b_frames, 6);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule